// File: doc/BRIEF.md
# Block Address Translation Array

This block translates a 32-bit effective address into a 32-bit physical address for large, aligned memory regions of 128 KB up to 256 MB. It holds four software-written entries and compares an incoming address against all of them in the same cycle. A per-entry length mask decides which address bits in the range 17 to 27 are left out of the compare and passed straight through to the physical address.

A page translation from an external TLB comes in beside each lookup. The block decides which translation wins. A block hit always takes precedence over a page hit. A page hit is used only when no block entry matches. When neither matches, a miss is reported. Separate instances serve the instruction side and the data side.

Lookups use a valid/ready request and response pair with a single output register stage. The entry write port is a plain single-cycle strobe.

Top module: `blk_xlate_array`

## Requirements
- R1: After reset, every entry is invalid for both privilege modes, `rsp_valid` is 0 and `req_ready` is 1. A lookup then reports a miss, unless the page input hits.
- R2: A block hit occurs when an entry is valid for the current mode and bits 31..28 of the effective address equal the entry's effective base. Bits 27..17 must also be equal wherever the mask bit is 0. The translated address takes its unmasked upper bits from the physical base, and bits 16..0 come unchanged from the effective address.
- R3: Mask bit k (k = 0..10) covers address bit 17+k. When it is 1, that bit is ignored in the compare and copied from the effective address into the physical address. Mask 0x000 gives a 128 KB block and 0x7FF gives a 256 MB block.
- R4: With `req_user`=1, an entry can match only if its user-valid bit is set. With `req_user`=0, it can match only if its supervisor-valid bit is set.
- R5: When several entries match, the response carries the lowest-numbered matching entry: its index, physical address, protection and attributes.
- R6: When a block hit and a page hit occur together, the block translation is returned, `rsp_blk_hit`=1 and `rsp_pg_used`=0.
- R7: When no block entry matches and `req_pg_hit`=1, `rsp_pa` equals `req_pg_pa`, `rsp_pg_used`=1, and protection and attributes are 0.
- R8: When neither block nor page matches, `rsp_miss`=1 and `rsp_pa`=0. Exactly one of `rsp_blk_hit`, `rsp_pg_used` and `rsp_miss` is 1 while `rsp_valid` is 1.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response shows `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, all response outputs hold steady and `req_ready` is 0.
- R10: A write with `wr_en`=1 replaces the whole entry `wr_idx` at the clock edge. A lookup accepted on that same edge still sees the old contents. Later lookups see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 2 | Entry index to write |
| wr_ebase | input | 15 | Effective base, address bits 31..17 |
| wr_pbase | input | 15 | Physical base, address bits 31..17 |
| wr_mask | input | 11 | Length mask, bit k covers address bit 17+k |
| wr_sup_ok | input | 1 | Entry valid in supervisor mode |
| wr_usr_ok | input | 1 | Entry valid in user mode |
| wr_prot | input | 2 | Protection field |
| wr_attr | input | 4 | Storage attribute field |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_pg_hit | input | 1 | Page TLB hit for this address |
| req_pg_pa | input | 32 | Page TLB physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pa | output | 32 | Selected physical address |
| rsp_blk_hit | output | 1 | Block translation used |
| rsp_pg_used | output | 1 | Page translation used |
| rsp_miss | output | 1 | Neither translation hit |
| rsp_idx | output | 2 | Winning entry index (0 if no block hit) |
| rsp_prot | output | 2 | Protection of the winning entry |
| rsp_attr | output | 4 | Attributes of the winning entry |

## Verification
The assertions assume that the request fields are meaningful whenever `req_valid` is 1. They also assume that the page-hit input and the page address belong to the same lookup. They do not depend on the response consumer ever raising `rsp_ready`.

The stimulus changes inputs only between clock edges. It raises `req_valid` for exactly one accepted request per lookup scenario. In the back-pressure scenario, it holds the waiting request steady until it is accepted. All writes use entry indices 0 to 3, and every mask value keeps unmasked bits aligned to the block size.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int BX_AW = 32;
  localparam int BX_LO = 17;
  localparam int BX_MW = 11;
  localparam int BX_BW = BX_AW - BX_LO;
  localparam int BX_PW = 2;
  localparam int BX_SW = 4;

  typedef struct packed {
    logic [BX_BW-1:0] ebase;
    logic [BX_BW-1:0] pbase;
    logic [BX_MW-1:0] mask;
    logic             sup_ok;
    logic             usr_ok;
    logic [BX_PW-1:0] prot;
    logic [BX_SW-1:0] attr;
  } bx_ent_t;
endpackage

// File: rtl/blkx_store.sv
module blkx_store
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  bx_ent_t       wr_ent,
  output bx_ent_t       ents [NUM_ENT]
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        ents[g] <= wr_ent;
      end
    end
  end
endmodule

// File: rtl/blkx_match.sv
module blkx_match
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bx_ent_t          ents [NUM_ENT],
  input  logic [BX_AW-1:0] ea,
  input  logic             user,
  output logic [NUM_ENT-1:0] match
);
  localparam int FIXW = BX_BW - BX_MW;
  logic [BX_BW-1:0] ea_hi;
  assign ea_hi = ea[BX_AW-1:BX_LO];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [BX_BW-1:0] care;
    logic             mode_ok;
    assign care    = ~{{FIXW{1'b0}}, ents[g].mask};
    assign mode_ok = user ? ents[g].usr_ok : ents[g].sup_ok;
    assign match[g] = mode_ok && (((ea_hi ^ ents[g].ebase) & care) == '0);

    // R4: a match needs the valid bit of the active privilege mode
    assert_priv_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match[g] |-> (user ? ents[g].usr_ok : ents[g].sup_ok));
  end
endmodule

// File: rtl/blkx_select.sv
module blkx_select
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bx_ent_t            ents [NUM_ENT],
  input  logic [NUM_ENT-1:0] match,
  input  logic [BX_AW-1:0]   ea,
  input  logic               pg_hit,
  input  logic [BX_AW-1:0]   pg_pa,
  output logic               blk_hit,
  output logic               pg_used,
  output logic               miss,
  output logic [IW-1:0]      idx,
  output logic [BX_AW-1:0]   pa,
  output logic [BX_PW-1:0]   prot,
  output logic [BX_SW-1:0]   attr
);
  localparam int FIXW = BX_BW - BX_MW;
  logic [BX_BW-1:0] care;
  logic [BX_BW-1:0] hi;

  always_comb begin
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
  end

  assign blk_hit = |match;
  assign pg_used = !blk_hit && pg_hit;
  assign miss    = !blk_hit && !pg_hit;
  assign care    = ~{{FIXW{1'b0}}, ents[idx].mask};
  assign hi      = (ents[idx].pbase & care) | (ea[BX_AW-1:BX_LO] & ~care);

  always_comb begin
    pa   = '0;
    prot = '0;
    attr = '0;
    if (blk_hit) begin
      pa   = {hi, ea[BX_LO-1:0]};
      prot = ents[idx].prot;
      attr = ents[idx].attr;
    end else if (pg_hit) begin
      pa = pg_pa;
    end
  end

  // R5: the chosen entry matches and no lower-numbered entry matches
  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit |-> (match[idx] && ((match & ((NUM_ENT'(1) << idx) - NUM_ENT'(1))) == '0)));
  // R6: the page translation never wins against a block match
  assert_block_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|match && pg_hit) |-> (!pg_used && pa[BX_LO-1:0] == ea[BX_LO-1:0]));
endmodule

// File: rtl/blk_xlate_array.sv
module blk_xlate_array
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [BX_BW-1:0] wr_ebase,
  input  logic [BX_BW-1:0] wr_pbase,
  input  logic [BX_MW-1:0] wr_mask,
  input  logic             wr_sup_ok,
  input  logic             wr_usr_ok,
  input  logic [BX_PW-1:0] wr_prot,
  input  logic [BX_SW-1:0] wr_attr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BX_AW-1:0] req_ea,
  input  logic             req_user,
  input  logic             req_pg_hit,
  input  logic [BX_AW-1:0] req_pg_pa,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [BX_AW-1:0] rsp_pa,
  output logic             rsp_blk_hit,
  output logic             rsp_pg_used,
  output logic             rsp_miss,
  output logic [IW-1:0]    rsp_idx,
  output logic [BX_PW-1:0] rsp_prot,
  output logic [BX_SW-1:0] rsp_attr
);
  bx_ent_t            ents [NUM_ENT];
  bx_ent_t            wr_ent;
  logic [NUM_ENT-1:0] match;
  logic               c_blk, c_pg, c_miss;
  logic [IW-1:0]      c_idx;
  logic [BX_AW-1:0]   c_pa;
  logic [BX_PW-1:0]   c_prot;
  logic [BX_SW-1:0]   c_attr;
  logic               accept;

  assign wr_ent = '{ebase: wr_ebase, pbase: wr_pbase, mask: wr_mask,
                    sup_ok: wr_sup_ok, usr_ok: wr_usr_ok,
                    prot: wr_prot, attr: wr_attr};

  blkx_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .ents(ents));

  blkx_match #(.NUM_ENT(NUM_ENT)) u_match (
    .clk(clk), .rst_n(rst_n), .ents(ents), .ea(req_ea),
    .user(req_user), .match(match));

  blkx_select #(.NUM_ENT(NUM_ENT)) u_sel (
    .clk(clk), .rst_n(rst_n), .ents(ents), .match(match), .ea(req_ea),
    .pg_hit(req_pg_hit), .pg_pa(req_pg_pa),
    .blk_hit(c_blk), .pg_used(c_pg), .miss(c_miss), .idx(c_idx),
    .pa(c_pa), .prot(c_prot), .attr(c_attr));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_blk_hit <= 1'b0;
      rsp_pg_used <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_idx     <= '0;
      rsp_prot    <= '0;
      rsp_attr    <= '0;
    end else begin
      if (accept) begin
        rsp_valid   <= 1'b1;
        rsp_pa      <= c_pa;
        rsp_blk_hit <= c_blk;
        rsp_pg_used <= c_pg;
        rsp_miss    <= c_miss;
        rsp_idx     <= c_idx;
        rsp_prot    <= c_prot;
        rsp_attr    <= c_attr;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R9: an accepted request shows up as a response on the next cycle
  assert_accept_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R9: a stalled response stays put and blocks new requests
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_idx)
      && $stable(rsp_blk_hit) && $stable(rsp_pg_used) && $stable(rsp_miss)));
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R2: offset bits inside the smallest block pass through on a block hit
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && |match) |=> (rsp_blk_hit && rsp_pa[BX_LO-1:0] == $past(req_ea[BX_LO-1:0])));
  // R8: exactly one outcome per response
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_blk_hit, rsp_pg_used, rsp_miss}) == 1));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_pa == '0));
endmodule

// File: tb/blk_xlate_array_tb.sv
module blk_xlate_array_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [14:0] wr_ebase = '0, wr_pbase = '0;
  logic [10:0] wr_mask = '0;
  logic        wr_sup_ok = 1'b0, wr_usr_ok = 1'b0;
  logic [1:0]  wr_prot = '0;
  logic [3:0]  wr_attr = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_ea = '0;
  logic        req_user = 1'b0, req_pg_hit = 1'b0;
  logic [31:0] req_pg_pa = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_pa;
  logic        rsp_blk_hit, rsp_pg_used, rsp_miss;
  logic [1:0]  rsp_idx, rsp_prot;
  logic [3:0]  rsp_attr;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  blk_xlate_array u_dut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic write_ent(input logic [1:0] idx, input logic [31:0] ebase_addr, input logic [31:0] pbase_addr,
                           input logic [10:0] mask, input logic sv, input logic uv,
                           input logic [1:0] prot, input logic [3:0] attr);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_ebase = ebase_addr[31:17]; wr_pbase = pbase_addr[31:17];
    wr_mask = mask; wr_sup_ok = sv; wr_usr_ok = uv; wr_prot = prot; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one accepted lookup, result sampled at the negedge after acceptance
  task automatic lookup(input string tag, input logic [31:0] ea, input logic user,
                        input logic pgh, input logic [31:0] pgpa,
                        input logic [2:0] exp_out, input logic [31:0] exp_pa,
                        input logic [1:0] exp_idx, input logic [1:0] exp_prot, input logic [3:0] exp_attr);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_user = user; req_pg_hit = pgh; req_pg_pa = pgpa;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "outcome{blk,pg,miss}", 32'({rsp_blk_hit, rsp_pg_used, rsp_miss}), 32'(exp_out));
    chk(tag, "pa", rsp_pa, exp_pa);
    if (exp_out == 3'b100) begin
      chk(tag, "idx", 32'(rsp_idx), 32'(exp_idx));
      chk(tag, "prot", 32'(rsp_prot), 32'(exp_prot));
      chk(tag, "attr", 32'(rsp_attr), 32'(exp_attr));
    end else begin
      chk(tag, "prot", 32'(rsp_prot), 32'd0);
      chk(tag, "attr", 32'(rsp_attr), 32'd0);
    end
  endtask

  localparam logic [2:0] BLK = 3'b100, PG = 3'b010, MISS = 3'b001;

  task automatic t_reset;
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    lookup("R1", 32'h1001_2345, 1'b0, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
    lookup("R8", 32'h0000_0000, 1'b1, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
  endtask

  task automatic t_basic;
    write_ent(2'd0, 32'h1000_0000, 32'h8000_0000, 11'h000, 1'b1, 1'b1, 2'd2, 4'd5);
    lookup("R2", 32'h1001_2345, 1'b0, 1'b0, 32'h0, BLK, 32'h8001_2345, 2'd0, 2'd2, 4'd5);
    lookup("R2", 32'h1001_FFFF, 1'b1, 1'b0, 32'h0, BLK, 32'h8001_FFFF, 2'd0, 2'd2, 4'd5);
    lookup("R2", 32'h1002_0000, 1'b0, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
  endtask

  task automatic t_mask;
    write_ent(2'd1, 32'h2000_0000, 32'h3000_0000, 11'h7FF, 1'b1, 1'b1, 2'd1, 4'd9);
    lookup("R3", 32'h2ABC_DEF0, 1'b0, 1'b0, 32'h0, BLK, 32'h3ABC_DEF0, 2'd1, 2'd1, 4'd9);
    write_ent(2'd2, 32'h4000_0000, 32'h5000_0000, 11'h003, 1'b1, 1'b1, 2'd3, 4'd1);
    lookup("R3", 32'h4007_1234, 1'b0, 1'b0, 32'h0, BLK, 32'h5007_1234, 2'd2, 2'd3, 4'd1);
    lookup("R3", 32'h4008_0000, 1'b0, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
  endtask

  task automatic t_priv;
    write_ent(2'd3, 32'h6000_0000, 32'h7000_0000, 11'h000, 1'b1, 1'b0, 2'd0, 4'd7);
    lookup("R4", 32'h6000_0010, 1'b0, 1'b0, 32'h0, BLK, 32'h7000_0010, 2'd3, 2'd0, 4'd7);
    lookup("R4", 32'h6000_0010, 1'b1, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
    write_ent(2'd3, 32'h6000_0000, 32'h7000_0000, 11'h000, 1'b0, 1'b1, 2'd0, 4'd7);
    lookup("R4", 32'h6000_0010, 1'b0, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
    lookup("R4", 32'h6000_0010, 1'b1, 1'b0, 32'h0, BLK, 32'h7000_0010, 2'd3, 2'd0, 4'd7);
  endtask

  task automatic t_prio;
    write_ent(2'd2, 32'h1000_0000, 32'h9000_0000, 11'h7FF, 1'b1, 1'b1, 2'd1, 4'd3);
    lookup("R5", 32'h1001_2345, 1'b0, 1'b0, 32'h0, BLK, 32'h8001_2345, 2'd0, 2'd2, 4'd5);
    write_ent(2'd0, 32'h1000_0000, 32'h8000_0000, 11'h000, 1'b0, 1'b0, 2'd2, 4'd5);
    lookup("R5", 32'h1001_2345, 1'b0, 1'b0, 32'h0, BLK, 32'h9001_2345, 2'd2, 2'd1, 4'd3);
  endtask

  task automatic t_page;
    lookup("R6", 32'h2000_0040, 1'b0, 1'b1, 32'hDEAD_0040, BLK, 32'h3000_0040, 2'd1, 2'd1, 4'd9);
    lookup("R7", 32'hF000_0000, 1'b0, 1'b1, 32'h1234_5678, PG, 32'h1234_5678, 2'd0, 2'd0, 4'd0);
    lookup("R8", 32'hF000_0000, 1'b0, 1'b0, 32'h1234_5678, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h2000_0100; req_user = 1'b0; req_pg_hit = 1'b0;
    @(negedge clk);
    req_ea = 32'hF000_0000; req_pg_hit = 1'b1; req_pg_pa = 32'h0000_ABCD;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "stall valid", 32'(rsp_valid), 32'd1);
      chk("R9", "stall ready low", 32'(req_ready), 32'd0);
      chk("R9", "stall pa held", rsp_pa, 32'h3000_0100);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "second rsp valid", 32'(rsp_valid), 32'd1);
    chk("R9", "second rsp page", 32'({rsp_blk_hit, rsp_pg_used, rsp_miss}), 32'(PG));
    chk("R9", "second rsp pa", rsp_pa, 32'h0000_ABCD);
    @(negedge clk);
    chk("R9", "drained", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd1; wr_ebase = 15'h1000; wr_pbase = 15'h1800; wr_mask = 11'h7FF;
    wr_sup_ok = 1'b0; wr_usr_ok = 1'b0; wr_prot = 2'd1; wr_attr = 4'd9;
    req_valid = 1'b1; req_ea = 32'h2000_0000; req_user = 1'b0; req_pg_hit = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R10", "old entry seen", 32'({rsp_blk_hit, rsp_pg_used, rsp_miss}), 32'(BLK));
    chk("R10", "old pa", rsp_pa, 32'h3000_0000);
    lookup("R10", 32'h2000_0000, 1'b0, 1'b0, 32'h0, MISS, 32'h0, 2'd0, 2'd0, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_priv();
    t_prio();
    t_page();
    t_stall();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule